// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a rectangular or linear region of memory and emits one source address and one destination address per accepted cycle for a block-transfer engine. Software supplies the two start addresses as separate high and low parts, the region width and height in pixels, and a row pitch. It also supplies a direction flag and a separate linear flag for each side. A pulse on `start` loads the job. The pairs then leave under a valid/ready handshake. After the last pair is taken, a one-cycle `done` pulse comes out together with the destination address that follows the region, so the caller can write it back.

Forward traversal starts at the top-left corner and runs left to right, then top to bottom. Reverse traversal starts at the bottom-right corner and runs right to left, then bottom to top. This lets a copy between overlapping regions proceed without overwriting unread source pixels. Each side is either a pitched rectangle or a run of consecutive addresses, independently of the other side.

Top module: `blit_addr_seq`

## Requirements
- R1: After reset `addr_valid`, `done` and `busy` are all 0.
- R2: With `reverse`=0 and a side's linear flag at 0, pixel k of that side (column x = k mod width, row y = k div width) has address start + y*pitch + x, modulo 2^20.
- R3: With `reverse`=1 and a side's linear flag at 0, pixel k has address start - y*pitch - x, modulo 2^20. Here start names the bottom-right pixel.
- R4: With `src_linear`=1 the source address of pixel k is start + k (forward) or start - k (reverse), and the pitch is ignored. This holds whatever the destination flag is.
- R5: With `dst_linear`=1 the destination address of pixel k is start + k or start - k in the same way, independently of the source flag.
- R6: Each start address is {hi[7:0], lo[11:0]}: the high part occupies bits 19:12 and the low part bits 11:0.
- R7: A `start` with width 0 or height 0 produces no valid cycle. `done` is 1 in the cycle after `start` is sampled, with `final_dst` equal to the destination start address.
- R8: While `addr_valid`=1 and `addr_ready`=0, both addresses and `addr_valid` hold their values into the next cycle.
- R9: `done` is a single-cycle pulse in the cycle after the last pair is accepted, and `addr_valid` is 0 whenever `done` is 1.
- R10: While `done`=1, `final_dst` is the destination address of pixel index width*height under the R2/R3/R5 rules: start ± height*pitch for a rectangle, start ± width*height for a linear run.
- R11: A `start` pulse while `busy`=1 is ignored, and the running job's addresses are unchanged.
- R12: Address arithmetic wraps modulo 2^20 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the job when idle |
| reverse | input | 1 | 0 forward, 1 reverse traversal |
| src_linear | input | 1 | Source is a consecutive run |
| dst_linear | input | 1 | Destination is a consecutive run |
| src_lo | input | 12 | Source start, low part |
| src_hi | input | 8 | Source start, high part |
| dst_lo | input | 12 | Destination start, low part |
| dst_hi | input | 8 | Destination start, high part |
| dim_x | input | 12 | Width in pixels |
| dim_y | input | 12 | Height in rows |
| pitch | input | 12 | Address distance between rows |
| addr_ready | input | 1 | Consumer accepts the current pair |
| addr_valid | output | 1 | Address pair is valid |
| src_addr | output | 20 | Current source address |
| dst_addr | output | 20 | Current destination address |
| busy | output | 1 | A job is loaded or finishing |
| done | output | 1 | One-cycle end-of-job pulse |
| final_dst | output | 20 | Destination address following the region |

## Verification
The vector table covers several input patterns. Forward and reverse pitched rectangles separate the two stepping directions and the row-to-row jump. Mixed linear/rectangular pairs show that each side's flag acts only on its own address. A fully linear run crossing the top of the address space, and a reverse rectangle crossing zero, expose any wrap fault. Stalled variants of the same jobs separate a sequencer that advances only on an accepted pair from one that advances on valid alone. Directed tests cover zero width and zero height, and a second `start` while busy.

// File: rtl/blit_addr_seq.sv
module blit_addr_seq #(
  parameter int LOW_W = 12,
  parameter int HI_W  = 8,
  parameter int DIM_W = 12,
  parameter int PIT_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   reverse,
  input  logic                   src_linear,
  input  logic                   dst_linear,
  input  logic [LOW_W-1:0]       src_lo,
  input  logic [HI_W-1:0]        src_hi,
  input  logic [LOW_W-1:0]       dst_lo,
  input  logic [HI_W-1:0]        dst_hi,
  input  logic [DIM_W-1:0]       dim_x,
  input  logic [DIM_W-1:0]       dim_y,
  input  logic [PIT_W-1:0]       pitch,
  input  logic                   addr_ready,
  output logic                   addr_valid,
  output logic [LOW_W+HI_W-1:0]  src_addr,
  output logic [LOW_W+HI_W-1:0]  dst_addr,
  output logic                   busy,
  output logic                   done,
  output logic [LOW_W+HI_W-1:0]  final_dst
);
  localparam int AW = LOW_W + HI_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic             rev_q, slin_q, dlin_q;
  logic [DIM_W-1:0] dx_q, dy_q, x_cnt, y_cnt;
  logic [AW-1:0]    pit_q;
  logic [AW-1:0]    s_cur, s_row, d_cur, d_row;
  logic [AW-1:0]    s_nxt, s_row_nxt, d_nxt, d_row_nxt;
  logic             last_col, last_pix, zero_dim, accept;

  assign zero_dim = (dim_x == '0) || (dim_y == '0);
  assign last_col = (x_cnt == dx_q - 1'b1);
  assign last_pix = last_col && (y_cnt == dy_q - 1'b1);
  assign accept   = (st == S_RUN) && addr_ready;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] cur,
                                               input logic [AW-1:0] row,
                                               input logic lin,
                                               input logic rev,
                                               input logic eol,
                                               input logic [AW-1:0] pit);
    if (!lin && eol) step_addr = rev ? row - pit : row + pit;
    else             step_addr = rev ? cur - 1'b1 : cur + 1'b1;
  endfunction

  assign s_nxt     = step_addr(s_cur, s_row, slin_q, rev_q, last_col, pit_q);
  assign d_nxt     = step_addr(d_cur, d_row, dlin_q, rev_q, last_col, pit_q);
  assign s_row_nxt = (!slin_q && last_col) ? s_nxt : s_row;
  assign d_row_nxt = (!dlin_q && last_col) ? d_nxt : d_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rev_q  <= 1'b0;
      slin_q <= 1'b0;
      dlin_q <= 1'b0;
      dx_q   <= '0;
      dy_q   <= '0;
      pit_q  <= '0;
      x_cnt  <= '0;
      y_cnt  <= '0;
      s_cur  <= '0;
      s_row  <= '0;
      d_cur  <= '0;
      d_row  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          rev_q  <= reverse;
          slin_q <= src_linear;
          dlin_q <= dst_linear;
          dx_q   <= dim_x;
          dy_q   <= dim_y;
          pit_q  <= {{(AW-PIT_W){1'b0}}, pitch};
          x_cnt  <= '0;
          y_cnt  <= '0;
          s_cur  <= {src_hi, src_lo};
          s_row  <= {src_hi, src_lo};
          d_cur  <= {dst_hi, dst_lo};
          d_row  <= {dst_hi, dst_lo};
          st     <= zero_dim ? S_FIN : S_RUN;
        end
        S_RUN: if (accept) begin
          s_cur <= s_nxt;
          s_row <= s_row_nxt;
          d_cur <= d_nxt;
          d_row <= d_row_nxt;
          x_cnt <= last_col ? '0 : x_cnt + 1'b1;
          y_cnt <= last_col ? y_cnt + 1'b1 : y_cnt;
          if (last_pix) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign addr_valid = (st == S_RUN);
  assign done       = (st == S_FIN);
  assign busy       = (st != S_IDLE);
  assign src_addr   = s_cur;
  assign dst_addr   = d_cur;
  assign final_dst  = d_cur;
endmodule

module blit_addr_seq_chk #(
  parameter int AW    = 20,
  parameter int DIM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [DIM_W-1:0] dim_x,
  input logic [DIM_W-1:0] dim_y,
  input logic             addr_ready,
  input logic             addr_valid,
  input logic [AW-1:0]    src_addr,
  input logic [AW-1:0]    dst_addr,
  input logic             busy,
  input logic             done
);
  assert_valid_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> busy);

  assert_zero_dim_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (dim_x == '0 || dim_y == '0)) |=> (done && !addr_valid));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(src_addr) && $stable(dst_addr)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && start && !addr_ready) |=> (addr_valid && $stable(dst_addr)));
endmodule

bind blit_addr_seq blit_addr_seq_chk #(.AW(LOW_W + HI_W), .DIM_W(DIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .dim_x(dim_x), .dim_y(dim_y),
  .addr_ready(addr_ready), .addr_valid(addr_valid), .src_addr(src_addr),
  .dst_addr(dst_addr), .busy(busy), .done(done)
);

// File: tb/blit_addr_seq_tb_top.sv
`timescale 1ns/1ps
module blit_addr_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, reverse, src_linear, dst_linear, addr_ready;
  logic [11:0] src_lo, dst_lo, dim_x, dim_y, pitch;
  logic [7:0]  src_hi, dst_hi;
  logic        addr_valid, busy, done;
  logic [19:0] src_addr, dst_addr, final_dst;

  blit_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .reverse(reverse),
    .src_linear(src_linear), .dst_linear(dst_linear),
    .src_lo(src_lo), .src_hi(src_hi), .dst_lo(dst_lo), .dst_hi(dst_hi),
    .dim_x(dim_x), .dim_y(dim_y), .pitch(pitch), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .src_addr(src_addr), .dst_addr(dst_addr),
    .busy(busy), .done(done), .final_dst(final_dst)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic        rev;
    logic        slin;
    logic        dlin;
    logic [19:0] src;
    logic [19:0] dst;
    logic [11:0] dx;
    logic [11:0] dy;
    logic [11:0] pit;
    logic        stall;
    logic [19:0] fin;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [0:NV-1] = '{
    '{1'b0, 1'b0, 1'b0, 20'h01000, 20'h20000, 12'd4, 12'd3, 12'h100, 1'b0, 20'h20300},
    '{1'b1, 1'b0, 1'b0, 20'h01203, 20'h30210, 12'd4, 12'd3, 12'h100, 1'b1, 20'h2FF10},
    '{1'b0, 1'b1, 1'b0, 20'h05000, 20'h40000, 12'd3, 12'd2, 12'h040, 1'b0, 20'h40080},
    '{1'b1, 1'b0, 1'b1, 20'h06100, 20'h50010, 12'd3, 12'd2, 12'h080, 1'b1, 20'h5000A},
    '{1'b0, 1'b1, 1'b1, 20'h00000, 20'hFFFFE, 12'd5, 12'd1, 12'h010, 1'b1, 20'h00003},
    '{1'b1, 1'b0, 1'b0, 20'h00011, 20'h00001, 12'd2, 12'd2, 12'h010, 1'b0, 20'hFFFE1},
    '{1'b0, 1'b0, 1'b0, 20'hABCDE, 20'h12345, 12'd1, 12'd4, 12'h200, 1'b1, 20'h12B45},
    '{1'b1, 1'b1, 1'b0, 20'h00002, 20'h7F7F7, 12'd3, 12'd3, 12'h020, 1'b1, 20'h7F797}
  };

  function automatic logic [19:0] model(input logic [19:0] st, input logic rev,
                                        input logic lin, input int k, input int dx,
                                        input int pit);
    int off;
    logic [31:0] r;
    off = lin ? k : (k / dx) * pit + (k % dx);
    r = rev ? (32'(st) - 32'(off)) : (32'(st) + 32'(off));
    return r[19:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [19:0] act,
                       input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    reverse = v.rev; src_linear = v.slin; dst_linear = v.dlin;
    src_hi = v.src[19:12]; src_lo = v.src[11:0];
    dst_hi = v.dst[19:12]; dst_lo = v.dst[11:0];
    dim_x = v.dx; dim_y = v.dy; pitch = v.pit;
  endtask

  task automatic run_job(input vec_t v, input string tag);
    int n, k, cyc;
    n = int'(v.dx) * int'(v.dy);
    load(v);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    k = 0; cyc = 0;
    while (k < n && cyc < 400) begin
      addr_ready = v.stall ? ((cyc % 3) != 1) : 1'b1;
      #0.1;
      if (addr_ready) begin
        check(addr_valid === 1'b1, {tag, " valid R9"}, {19'd0, addr_valid}, 20'd1);
        check(src_addr === model(v.src, v.rev, v.slin, k, v.dx, v.pit),
              {tag, " src R2 R3 R4 R6 R12"}, src_addr,
              model(v.src, v.rev, v.slin, k, v.dx, v.pit));
        check(dst_addr === model(v.dst, v.rev, v.dlin, k, v.dx, v.pit),
              {tag, " dst R2 R3 R5 R6 R12"}, dst_addr,
              model(v.dst, v.rev, v.dlin, k, v.dx, v.pit));
        k++;
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    addr_ready = 1'b0;
    check(done === 1'b1 && addr_valid === 1'b0, {tag, " done after last R9"},
          {18'd0, done, addr_valid}, 20'd2);
    check(final_dst === v.fin, {tag, " final_dst R10"}, final_dst, v.fin);
    @(negedge clk);
    check(done === 1'b0, {tag, " done single pulse R9"}, {19'd0, done}, 20'd0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t z;
    vec_t a;
    vec_t b;
    rst_n = 1'b0; start = 1'b0; addr_ready = 1'b0;
    load(VT[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(addr_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "reset R1",
          {17'd0, addr_valid, done, busy}, 20'd0);

    for (int i = 0; i < NV; i++) run_job(VT[i], $sformatf("vec%0d", i));

    // R7 zero width
    z = VT[0]; z.dx = 12'd0; z.dy = 12'd3;
    load(z); start = 1'b1; addr_ready = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    check(done === 1'b1 && addr_valid === 1'b0, "zero width R7",
          {18'd0, done, addr_valid}, 20'd2);
    check(final_dst === z.dst, "zero width final R7", final_dst, z.dst);
    @(negedge clk);
    check(busy === 1'b0 && addr_valid === 1'b0, "zero width idle R7",
          {18'd0, busy, addr_valid}, 20'd0);

    // R7 zero height
    z = VT[1]; z.dx = 12'd5; z.dy = 12'd0;
    load(z); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    check(done === 1'b1 && addr_valid === 1'b0, "zero height R7",
          {18'd0, done, addr_valid}, 20'd2);
    @(negedge clk);
    addr_ready = 1'b0;

    // R11 start while busy
    a = VT[0]; a.dx = 12'd2; a.dy = 12'd2; a.fin = 20'h20200;
    b = VT[3];
    load(a); start = 1'b1;
    @(posedge clk); @(negedge clk);
    load(b);
    repeat (2) @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      addr_ready = 1'b1;
      #0.1;
      check(dst_addr === model(a.dst, a.rev, a.dlin, k, a.dx, a.pit),
            "restart ignored dst R11", dst_addr,
            model(a.dst, a.rev, a.dlin, k, a.dx, a.pit));
      check(src_addr === model(a.src, a.rev, a.slin, k, a.dx, a.pit),
            "restart ignored src R11", src_addr,
            model(a.src, a.rev, a.slin, k, a.dx, a.pit));
      @(posedge clk); @(negedge clk);
    end
    addr_ready = 1'b0;
    check(done === 1'b1 && final_dst === a.fin, "restart final R11 R10",
          final_dst, a.fin);
    @(negedge clk);

    // R8 long stall hold
    load(VT[1]); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    check(addr_valid === 1'b1 && dst_addr === VT[1].dst, "stall hold R8",
          dst_addr, VT[1].dst);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule